// File: doc/BRIEF.md
# Bit-Band Alias Bridge

The bridge sits between a bus master and a target memory. It gives every 32-bit word of a 32 MB alias window the meaning of a single bit in a 1 MB target region. The slave port accepts one access at a time, of byte, halfword or word size. The bridge works out which target unit and which bit the alias address selects, then drives a master port that has a request/ready handshake. The target region's base address is a parameter. A typical system has two instances: one with an SRAM base of 0x20000000 behind the alias at 0x22000000, and one with a peripheral base of 0x40000000 behind the alias at 0x42000000.

A read fetches the target unit and returns the selected bit in bit 0. A write is an atomic read-modify-write. The bridge fetches the unit, forces the selected bit to bit 0 of the write data, and stores the unit back. The byte enables cover only the unit the access size names. Little-endian lane order is assumed.

The sequencer has four states. IDLE accepts a request (transition "accept", IDLE to FETCH). FETCH holds the target read until ready. It then goes to REPLY ("read done") for a read, or to STORE ("fetch done") for a write. STORE holds the write-back until ready, then goes to REPLY ("store done"). REPLY raises the slave ready for one cycle and goes back to IDLE ("release").

Top module: `bb_alias_bridge`

## Requirements
- R1: The target byte address is BASE OR (s_addr[24:0] >> 5). Bits 31..25 of s_addr have no effect.
- R2: s_size is encoded as follows. 0 is a byte access: the unit address is the target byte address and the bit index is s_addr[4:2]. 1 is a halfword access: the unit address is aligned down to 2 and the bit index is s_addr[5:2]. 2 and 3 are word accesses: the unit address is aligned down to 4 and the bit index is s_addr[6:2]. m_addr carries the unit address.
- R3: A read returns the selected bit of the target unit in s_rdata[0], with s_rdata[31:1] zero. Bit index k of a unit at lane offset L is bit 8*L+k of the little-endian 32-bit target word.
- R4: A write stores the unit back with the selected bit equal to s_wdata[0] and every other bit of the unit unchanged. s_wdata[31:1] has no effect.
- R5: On a target write, m_be has one lane for a byte access (lane m_addr[1:0]). A halfword access has lanes 1:0 or 3:2, chosen by m_addr[1]. A word access has all four lanes.
- R6: Only one transaction is in flight at a time. s_ready is a one-cycle pulse. A read takes at least two cycles from acceptance to s_ready and makes exactly one target read.
- R7: A write makes exactly one target read, then one target write to the same address. s_ready only follows the write-back acknowledge. m_req, m_we, m_addr and m_wdata hold steady while m_ready is low.
- R8: During and just after reset, s_ready and m_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_req | input | 1 | Slave request, held until s_ready |
| s_we | input | 1 | Slave write (1) or read (0) |
| s_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| s_addr | input | ADDR_W | Alias address |
| s_wdata | input | 32 | Write data, bit 0 used |
| s_ready | output | 1 | Transaction complete pulse |
| s_rdata | output | 32 | Read result, bit 0 only |
| m_req | output | 1 | Target request |
| m_we | output | 1 | Target write (1) or read (0) |
| m_addr | output | ADDR_W | Target unit address |
| m_be | output | 4 | Target byte enables |
| m_wdata | output | 32 | Target write data |
| m_ready | input | 1 | Target acknowledge, read data valid |
| m_rdata | input | 32 | Target read data (whole word) |

## Verification
On every cycle the assertions check the following: the one-cycle ready pulse, that the target request holds its command, address and data until acknowledged, and that a write-back acknowledge is followed by s_ready. They also check the lane count and unit alignment each access size allows. Only the bench scenarios can show that the right bit of the right unit is read or changed, and that neighbouring bits and lanes survive a write. The same holds for the masking of upper alias bits, the top-of-window boundary and behaviour under varied target wait states. A bench memory and a behavioural address model give the expected values for these.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned POS_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'd0,
        SZ_HALF     = 2'd1,
        SZ_WORD     = 2'd2,
        SZ_WORD_ALT = 2'd3
    } bb_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_REPLY
    } bb_state_e;
endpackage

// File: rtl/bb_addr_decode.sv
module bb_addr_decode
    import bb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned WIN_BITS = 25,
    parameter int unsigned SHIFT    = 5,
    parameter logic [ADDR_W-1:0] BASE = 32'h2000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  bb_size_e          size,
    output logic [ADDR_W-1:0] unit_addr,
    output logic [POS_W-1:0]  bit_pos,
    output logic [LANES-1:0]  be
);
    localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((64'd1 << WIN_BITS) - 1);

    logic [ADDR_W-1:0] tgt;
    logic [POS_W-1:0]  idx;

    assign tgt = BASE | ((addr & WIN_MASK) >> SHIFT);
    assign idx = addr[POS_W+1:2];

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                unit_addr = tgt;
                bit_pos   = {tgt[1:0], idx[2:0]};
                be        = LANES'(1) << tgt[1:0];
            end
            SZ_HALF: begin
                unit_addr = {tgt[ADDR_W-1:1], 1'b0};
                bit_pos   = {tgt[1], idx[3:0]};
                be        = tgt[1] ? 4'b1100 : 4'b0011;
            end
            default: begin
                unit_addr = {tgt[ADDR_W-1:2], 2'b00};
                bit_pos   = idx;
                be        = '1;
            end
        endcase
    end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
    import bb_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [POS_W-1:0]  pos,
    input  logic              set_val,
    output logic [DATA_W-1:0] merged,
    output logic              bit_val
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign merged[i] = (pos == POS_W'(i)) ? set_val : word[i];
    end
    assign bit_val = word[pos];
endmodule

// File: rtl/bb_seq.sv
module bb_seq
    import bb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      s_req,
    input  logic      s_we,
    input  logic      m_ready,
    output bb_state_e state,
    output logic      accept,
    output logic      fetch_ack,
    output logic      s_ready,
    output logic      m_req,
    output logic      m_we
);
    bb_state_e nxt;
    logic      we_q;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (s_req)   nxt = ST_FETCH;
            ST_FETCH: if (m_ready) nxt = we_q ? ST_STORE : ST_REPLY;
            ST_STORE: if (m_ready) nxt = ST_REPLY;
            ST_REPLY: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            we_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) we_q <= s_we;
        end
    end

    always_comb begin
        accept    = 1'b0;
        fetch_ack = 1'b0;
        s_ready   = 1'b0;
        m_req     = 1'b0;
        m_we      = 1'b0;
        unique case (state)
            ST_IDLE:  accept = s_req;
            ST_FETCH: begin
                m_req     = 1'b1;
                fetch_ack = m_ready;
            end
            ST_STORE: begin
                m_req = 1'b1;
                m_we  = 1'b1;
            end
            ST_REPLY: s_ready = 1'b1;
        endcase
    end

    a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);
    a_r7_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ready) |=> (m_req && $stable(m_we)));
    a_r7_reply_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we && m_ready) |=> s_ready);
    a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> !accept);
endmodule

// File: rtl/bb_alias_bridge.sv
module bb_alias_bridge
    import bb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned WIN_BITS = 25,
    parameter int unsigned SHIFT    = 5,
    parameter logic [ADDR_W-1:0] BASE = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_req,
    input  logic              s_we,
    input  logic [1:0]        s_size,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [31:0]       s_wdata,
    output logic              s_ready,
    output logic [31:0]       s_rdata,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [3:0]        m_be,
    output logic [31:0]       m_wdata,
    input  logic              m_ready,
    input  logic [31:0]       m_rdata
);
    bb_state_e         state;
    logic              accept, fetch_ack;
    logic [ADDR_W-1:0] addr_q;
    bb_size_e          size_q;
    logic              wbit_q, rbit_q;
    logic [DATA_W-1:0] wword_q, merged;
    logic [POS_W-1:0]  pos;
    logic              bit_val;
    logic [LANES-1:0]  be;
    logic              wd_bit;

    assign wd_bit = (s_wdata & 32'h1) != 32'h0;

    bb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .m_ready(m_ready),
        .state(state), .accept(accept), .fetch_ack(fetch_ack),
        .s_ready(s_ready), .m_req(m_req), .m_we(m_we)
    );

    bb_addr_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .SHIFT(SHIFT), .BASE(BASE)) u_dec (
        .addr(addr_q), .size(size_q), .unit_addr(m_addr), .bit_pos(pos), .be(be)
    );

    bb_bit_merge u_merge (
        .word(m_rdata), .pos(pos), .set_val(wbit_q), .merged(merged), .bit_val(bit_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= SZ_WORD;
            wbit_q  <= 1'b0;
            rbit_q  <= 1'b0;
            wword_q <= '0;
        end else begin
            if (accept) begin
                addr_q <= s_addr;
                size_q <= bb_size_e'(s_size);
                wbit_q <= wd_bit;
            end
            if (fetch_ack) begin
                rbit_q  <= bit_val;
                wword_q <= merged;
            end
        end
    end

    assign m_be    = be;
    assign m_wdata = wword_q;
    assign s_rdata = {31'b0, rbit_q};

    a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ready) |=> ($stable(m_addr) && $stable(m_wdata)));
    a_r5_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && size_q == SZ_BYTE) |-> ($countones(m_be) == 1));
    a_r5_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && size_q == SZ_HALF) |-> (!m_addr[0] && (m_be == 4'b0011 || m_be == 4'b1100)));
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && size_q[1]) |-> (m_addr[1:0] == 2'b00 && m_be == 4'hF));
endmodule

// File: tb/test_bb_alias_bridge.sv
`timescale 1ns/1ps
module test_bb_alias_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_req = 1'b0, s_we = 1'b0;
    logic [1:0]  s_size = 2'd0;
    logic [31:0] s_addr = '0, s_wdata = '0;
    logic        s_ready;
    logic [31:0] s_rdata;
    logic        m_req, m_we;
    logic [31:0] m_addr, m_wdata;
    logic [3:0]  m_be;
    logic        m_ready = 1'b0;
    logic [31:0] m_rdata = '0;

    int errors = 0, checks = 0;
    logic [31:0] mem [0:255];
    logic [31:0] exp_addr;
    logic [3:0]  exp_be;
    int ops = 0, mem_lat = 0, lat_cnt = 0, cyc = 0;
    logic in_txn = 1'b0, exp_we = 1'b0;

    always #2.5 clk = ~clk;

    bb_alias_bridge i_bb_alias_bridge (
        .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_size(s_size),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_be(m_be), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_rdata(m_rdata)
    );

    task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural target memory and per-cycle reference comparison
    always @(negedge clk) begin
        if (m_ready) begin
            m_ready = 1'b0;
            lat_cnt = 0;
        end else if (m_req) begin
            chk("R6 request only inside a transaction", in_txn, 32'(m_req), 32'(in_txn));
            chk("R1 target address", m_addr == exp_addr, m_addr, exp_addr);
            chk("R7 read phase before write phase", m_we == (ops > 0), 32'(m_we), 32'(ops > 0));
            if (m_we) chk("R5 write byte lanes", m_be == exp_be, 32'(m_be), 32'(exp_be));
            if (lat_cnt >= mem_lat) begin
                m_rdata = mem[m_addr[9:2]];
                if (m_we)
                    for (int b = 0; b < 4; b++)
                        if (m_be[b]) mem[m_addr[9:2]][8*b +: 8] = m_wdata[8*b +: 8];
                m_ready = 1'b1;
                ops++;
            end else lat_cnt++;
        end
    end

    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic we,
                          input logic [31:0] wd, input int lat, input string tag);
        logic [31:0] tgt, ua, old, expw;
        int pos;
        tgt = 32'h2000_0000 | ((a & 32'h01FF_FFFF) >> 5);
        if (sz == 2'd0) begin
            ua = tgt; pos = int'(tgt[1:0]) * 8 + int'(a[4:2]); exp_be = 4'b0001 << tgt[1:0];
        end else if (sz == 2'd1) begin
            ua = tgt & ~32'h1; pos = int'(ua[1]) * 16 + int'(a[5:2]); exp_be = ua[1] ? 4'hC : 4'h3;
        end else begin
            ua = tgt & ~32'h3; pos = int'(a[6:2]); exp_be = 4'hF;
        end
        old = mem[ua[9:2]];
        expw = old; expw[pos] = wd[0];
        exp_addr = ua; exp_we = we; ops = 0; mem_lat = lat; in_txn = 1'b1;
        @(negedge clk);
        s_req = 1'b1; s_we = we; s_size = sz; s_addr = a; s_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!s_ready);
        s_req = 1'b0;
        in_txn = 1'b0;
        if (!we) begin
            chk({"R3 read value ", tag}, s_rdata == {31'b0, old[pos]}, s_rdata, {31'b0, old[pos]});
            chk({"R6 read latency ", tag}, cyc >= 2, cyc, 2);
            chk({"R6 one target read ", tag}, ops == 1, ops, 1);
        end else begin
            chk({"R4 written unit ", tag}, mem[ua[9:2]] == expw, mem[ua[9:2]], expw);
            chk({"R7 two target phases ", tag}, ops == 2, ops, 2);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = (i * 32'h9E37_79B1) ^ 32'hA5C3_0F96;
        repeat (3) @(negedge clk);
        chk("R8 s_ready in reset", s_ready == 1'b0, 32'(s_ready), 0);
        chk("R8 m_req in reset", m_req == 1'b0, 32'(m_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 s_ready after reset", s_ready == 1'b0, 32'(s_ready), 0);
        chk("R8 m_req after reset", m_req == 1'b0, 32'(m_req), 0);

        for (int b = 0; b < 8; b++)
            access(32'h2200_0000 | (5 << 5) | (b << 2), 2'd0, 1'b0, 0, b % 3, "R2 byte read");
        for (int b = 0; b < 16; b += 3)
            access(32'h2200_0000 | (6 << 5) | (b << 2), 2'd1, 1'b0, 0, 1, "R2 half read");
        for (int b = 0; b < 32; b += 5)
            access(32'h2200_0000 | (8 << 5) | (b << 2), 2'd2, 1'b0, 0, b % 4, "R2 word read");
        access(32'h2200_0000 | (12 << 5) | (9 << 2), 2'd3, 1'b0, 0, 0, "R2 size3 word");

        access(32'h2200_0000 | (3 << 5) | (6 << 2), 2'd0, 1'b1, 32'h1, 0, "R5 byte set lane3");
        access(32'h2200_0000 | (3 << 5) | (6 << 2), 2'd0, 1'b1, 32'h0, 2, "R5 byte clear lane3");
        access(32'h2200_0000 | (3 << 5) | (6 << 2), 2'd0, 1'b0, 0, 0, "R3 readback");
        access(32'h2200_0000 | (10 << 5) | (13 << 2), 2'd1, 1'b1, 32'hFFFF_FFFE, 1, "R4 ignore upper wdata");
        access(32'h2200_0000 | (10 << 5) | (13 << 2), 2'd1, 1'b1, 32'h0000_0001, 3, "R4 half set");
        access(32'h2200_0000 | (16 << 5) | (31 << 2), 2'd2, 1'b1, 32'h3, 0, "R4 word set");
        access(32'h2200_0000 | (16 << 5) | (31 << 2), 2'd2, 1'b0, 0, 1, "R3 word readback");
        access(32'hFE00_0000 | (5 << 5) | (2 << 2), 2'd0, 1'b0, 0, 0, "R1 upper bits ignored");
        access(32'hFC00_0000 | (7 << 5) | (4 << 2), 2'd0, 1'b1, 32'h1, 1, "R1 upper bits write");
        access(32'h23FF_FFFC, 2'd2, 1'b0, 0, 0, "R1 window top");
        access(32'h23FF_FFFC, 2'd0, 1'b1, 32'h0, 2, "R1 window top byte");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule